// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the register front end of an I/O interrupt router. A 32-bit synchronous bus sees only two locations. One is a selector register. The other is a data window that reaches whichever internal register the selector names. Behind the window are a 4-bit identification field, a read-only version word, an arbitration word that always reads zero, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves.

The block holds the table and its reset values. It exports the whole table as a flat bus to the dispatch logic next to it, and it gives that logic a per-entry port to clear the remote-IRR bit. Each time a table half is written, the block pulses a one-cycle service strobe so that the dispatch logic re-evaluates its pending interrupts. Dispatch, pending-state tracking and delivery live in the neighbouring block.

Top module: `irr_window_regs`

## Requirements
- R1: Only the 8-bit address is decoded. Address 0x00 is the selector. A write stores wdata[7:0] there, and a read returns the selector zero-extended. For a read (cs=1, we=0), rdata shows the value one clock later and holds it until the next read.
- R2: Addresses other than 0x00 and 0x10 read as zero. Writes to them change no state.
- R3: Selector 0x00 names the ID field. It reads back in bits 27:24 with all other bits zero. A window write stores only wdata[27:24], and no other access changes the field.
- R4: Selector 0x01 reads 0x11 in bits 7:0 and ENTRIES-1 in bits 23:16. With the default of 24 entries the word is 0x00170011. Writes to it are ignored.
- R5: Selector 0x02 and selectors 0x03 to 0x0F read as zero. Window writes to them change no state.
- R6: A selector s >= 0x10 names entry (s-0x10)>>1. An even s addresses bits 31:0 of the entry and an odd s addresses bits 63:32.
- R7: A window write to one half of an entry leaves the other half unchanged.
- R8: A selector whose entry index is ENTRIES or higher reads as zero. A write through it is discarded and raises no service strobe.
- R9: svc_strobe is high for exactly the one cycle after each accepted table write, and low after any other access.
- R10: Reset clears the ID, the selector, rdata and svc_strobe. It sets every entry to 0x0000_0000_0001_0000, so that only mask bit 16 is set.
- R11: table_flat[64k +: 64] is entry k. It shows a write in the cycle after the write.
- R12: A high rirr_clr[k] clears bit 14 of entry k in the next cycle. If a window write to the low half of that entry lands in the same cycle, the written data is stored with bit 14 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset (0x00 selector, 0x10 window) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| svc_strobe | output | 1 | One-cycle request for a dispatch re-evaluation |
| rirr_clr | input | ENTRIES | Per-entry remote-IRR clear from dispatch |
| table_flat | output | 64*ENTRIES | All entries, entry k at bits 64k+63:64k |

## Verification
The window is driven with a table of accesses. Each read pairs a selector value with an expected word. The selector values cover the ID, the version, the arbitration word, the reserved gap, the even and odd halves of the first and last entries, and indices past the table. These separate a decode that ignores the low selector bit or picks the wrong half from one that maps correctly. They also separate a range check that is off by one at the last entry. Write patterns with all ones show whether stray ID bits are stored or writes to read-only words leak through. Directed sequences place the remote-IRR clear alone and in the same cycle as a low-half write, check the service strobe after table and non-table writes, and apply reset in the middle of the run.

// File: rtl/irr_pkg.sv
package irr_pkg;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] SEL_IDENT  = 8'h00;
  localparam logic [7:0] SEL_VERS   = 8'h01;
  localparam logic [7:0] SEL_ARBIT  = 8'h02;
  localparam logic [7:0] SEL_TBASE  = 8'h10;

  localparam logic [7:0] VERS_CODE  = 8'h11;
  localparam int         IDENT_LSB  = 24;
  localparam int         MASK_BIT   = 16;
  localparam int         RIRR_BIT   = 14;

  typedef enum logic [2:0] {
    RK_ZERO,
    RK_SELECT,
    RK_IDENT,
    RK_VERS,
    RK_TABLE
  } rd_kind_e;

  // Entry index named by a selector (valid only for sel >= SEL_TBASE)
  function automatic logic [7:0] f_entry_index(input logic [7:0] sel);
    logic [7:0] off;
    off = sel - SEL_TBASE;
    return {1'b0, off[7:1]};
  endfunction

  // Version word: code in low byte, highest entry index in 23:16
  function automatic logic [31:0] f_vers_word(input int entries);
    logic [7:0] top_idx;
    top_idx = 8'(entries - 1);
    return {8'h00, top_idx, 8'h00, VERS_CODE};
  endfunction

  // Reset value of one entry: masked, everything else clear
  function automatic logic [63:0] f_entry_reset();
    logic [63:0] v;
    v = '0;
    v[MASK_BIT] = 1'b1;
    return v;
  endfunction

  // ID field placed in the data word
  function automatic logic [31:0] f_ident_word(input logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction

endpackage

// File: rtl/irr_win_decode.sv
module irr_win_decode
  import irr_pkg::*;
#(
  parameter int ENTRIES = 24,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            cs,
  input  logic            we,
  input  logic [7:0]      addr,
  input  logic [7:0]      sel,
  output logic            sel_wr,
  output logic            id_wr,
  output logic            tbl_wr,
  output logic [IDXW-1:0] tbl_idx,
  output logic            tbl_hi,
  output rd_kind_e        rd_kind
);

  localparam logic [7:0] NENT8 = 8'(ENTRIES);

  logic       at_sel, at_win, tbl_hit;
  logic [7:0] idx8;

  assign at_sel  = (addr == OFS_SELECT);
  assign at_win  = (addr == OFS_WINDOW);
  assign idx8    = f_entry_index(sel);
  assign tbl_hit = (sel >= SEL_TBASE) && (idx8 < NENT8);
  assign tbl_idx = idx8[IDXW-1:0];
  assign tbl_hi  = sel[0];

  assign sel_wr  = cs && we && at_sel;
  assign id_wr   = cs && we && at_win && (sel == SEL_IDENT);
  assign tbl_wr  = cs && we && at_win && tbl_hit;

  always_comb begin
    rd_kind = RK_ZERO;
    if (at_sel) begin
      rd_kind = RK_SELECT;
    end else if (at_win) begin
      if (sel == SEL_IDENT)      rd_kind = RK_IDENT;
      else if (sel == SEL_VERS)  rd_kind = RK_VERS;
      else if (tbl_hit)          rd_kind = RK_TABLE;
      else                       rd_kind = RK_ZERO;
    end
  end

endmodule

// File: rtl/irr_entry_table.sv
module irr_entry_table
  import irr_pkg::*;
#(
  parameter int ENTRIES = 24,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tbl_wr,
  input  logic [IDXW-1:0]       tbl_idx,
  input  logic                  tbl_hi,
  input  logic [31:0]           wdata,
  input  logic [ENTRIES-1:0]    rirr_clr,
  output logic [31:0]           rd_word,
  output logic [64*ENTRIES-1:0] table_flat
);

  logic [63:0] ent [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    logic hit_lo, hit_hi;
    assign hit_lo = tbl_wr && (tbl_idx == IDXW'(k)) && !tbl_hi;
    assign hit_hi = tbl_wr && (tbl_idx == IDXW'(k)) &&  tbl_hi;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[k] <= f_entry_reset();
      end else begin
        if (hit_lo) ent[k][31:0]  <= wdata;
        if (hit_hi) ent[k][63:32] <= wdata;
        if (rirr_clr[k]) ent[k][RIRR_BIT] <= 1'b0;
      end
    end

    assign table_flat[64*k +: 64] = ent[k];

    // R7: writing the low half keeps the high half
    a_r7_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lo |=> $stable(ent[k][63:32]));

    // R12: a clear request leaves bit 14 low next cycle
    a_r12_rirr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      rirr_clr[k] |=> !ent[k][RIRR_BIT]);
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (tbl_idx == IDXW'(k))
        rd_word = tbl_hi ? ent[k][63:32] : ent[k][31:0];
    end
  end

endmodule

// File: rtl/irr_rd_mux.sv
module irr_rd_mux
  import irr_pkg::*;
#(
  parameter int ENTRIES = 24
) (
  input  rd_kind_e    rd_kind,
  input  logic [7:0]  sel,
  input  logic [3:0]  ident,
  input  logic [31:0] tbl_word,
  output logic [31:0] word
);

  always_comb begin
    unique case (rd_kind)
      RK_SELECT: word = {24'h0, sel};
      RK_IDENT:  word = f_ident_word(ident);
      RK_VERS:   word = f_vers_word(ENTRIES);
      RK_TABLE:  word = tbl_word;
      default:   word = '0;
    endcase
  end

endmodule

// File: rtl/irr_window_regs.sv
module irr_window_regs
  import irr_pkg::*;
#(
  parameter int ENTRIES = 24,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  we,
  input  logic [7:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  svc_strobe,
  input  logic [ENTRIES-1:0]    rirr_clr,
  output logic [64*ENTRIES-1:0] table_flat
);

  logic [7:0]      sel_q;
  logic [3:0]      id_q;
  logic [31:0]     rdata_q;
  logic            svc_q;

  logic            sel_wr, id_wr, tbl_wr, tbl_hi;
  logic [IDXW-1:0] tbl_idx;
  rd_kind_e        rd_kind;
  logic [31:0]     tbl_word, rd_word;
  logic            rd_req;

  assign rd_req = cs && !we;

  irr_win_decode #(.ENTRIES(ENTRIES)) u_dec (
    .cs(cs), .we(we), .addr(addr), .sel(sel_q),
    .sel_wr(sel_wr), .id_wr(id_wr), .tbl_wr(tbl_wr),
    .tbl_idx(tbl_idx), .tbl_hi(tbl_hi), .rd_kind(rd_kind)
  );

  irr_entry_table #(.ENTRIES(ENTRIES)) u_tbl (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx),
    .tbl_hi(tbl_hi), .wdata(wdata), .rirr_clr(rirr_clr),
    .rd_word(tbl_word), .table_flat(table_flat)
  );

  irr_rd_mux #(.ENTRIES(ENTRIES)) u_mux (
    .rd_kind(rd_kind), .sel(sel_q), .ident(id_q),
    .tbl_word(tbl_word), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      id_q    <= '0;
      rdata_q <= '0;
      svc_q   <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= wdata[7:0];
      if (id_wr)  id_q  <= wdata[IDENT_LSB +: 4];
      if (rd_req) rdata_q <= rd_word;
      svc_q <= tbl_wr;
    end
  end

  assign rdata      = rdata_q;
  assign svc_strobe = svc_q;

  // R9: the strobe only follows an accepted table write
  a_r9_svc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    svc_strobe |-> $past(tbl_wr));

  // R3: the ID field moves only on an ID write
  a_r3_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !id_wr |=> $stable(id_q));

  // R8: a window write past the table leaves the table untouched
  a_r8_oob_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == OFS_WINDOW && sel_q >= SEL_TBASE && !tbl_wr
     && rirr_clr == '0) |=> $stable(table_flat));

  // R1: the selector moves only on a write to offset 0x00
  a_r1_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && we && addr == OFS_SELECT) |=> $stable(sel_q));

endmodule

// File: tb/sim_irr_window_regs.sv
module sim_irr_window_regs;

  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int NV = 38;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs = 1'b0;
  logic              we = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              svc_strobe;
  logic [N-1:0]      rirr_clr = '0;
  logic [64*N-1:0]   table_flat;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sel_model = 8'h00;

  irr_window_regs #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .svc_strobe(svc_strobe),
    .rirr_clr(rirr_clr), .table_flat(table_flat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {we, addr, wdata, expected read, requirement}
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0000_0A12, 32'h0, 8'd1},           // R1 selector write
    {1'b0, 8'h00, 32'h0,         32'h0000_0012, 8'd1},   // R1 read back low byte
    {1'b1, 8'h00, 32'h0000_0000, 32'h0, 8'd3},
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 8'd3},
    {1'b0, 8'h10, 32'h0,         32'h0F00_0000, 8'd3},   // R3 only 27:24 kept
    {1'b1, 8'h00, 32'h0000_0001, 32'h0, 8'd4},
    {1'b0, 8'h10, 32'h0,         32'h0017_0011, 8'd4},   // R4 version word
    {1'b1, 8'h10, 32'h0000_0000, 32'h0, 8'd4},
    {1'b0, 8'h10, 32'h0,         32'h0017_0011, 8'd4},   // R4 write ignored
    {1'b1, 8'h00, 32'h0000_0002, 32'h0, 8'd5},
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 8'd5},
    {1'b0, 8'h10, 32'h0,         32'h0, 8'd5},           // R5 arbitration zero
    {1'b1, 8'h00, 32'h0000_0010, 32'h0, 8'd10},
    {1'b0, 8'h10, 32'h0,         32'h0001_0000, 8'd10},  // R10 reset low half
    {1'b1, 8'h10, 32'hA5A5_00C3, 32'h0, 8'd6},
    {1'b0, 8'h10, 32'h0,         32'hA5A5_00C3, 8'd6},   // R6 even = low
    {1'b1, 8'h00, 32'h0000_0011, 32'h0, 8'd10},
    {1'b0, 8'h10, 32'h0,         32'h0, 8'd10},          // R10 reset high half
    {1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0, 8'd6},
    {1'b0, 8'h10, 32'h0,         32'hDEAD_BEEF, 8'd6},   // R6 odd = high
    {1'b1, 8'h00, 32'h0000_0010, 32'h0, 8'd7},
    {1'b0, 8'h10, 32'h0,         32'hA5A5_00C3, 8'd7},   // R7 low kept
    {1'b1, 8'h00, 32'h0000_003F, 32'h0, 8'd6},
    {1'b1, 8'h10, 32'h1234_5678, 32'h0, 8'd6},
    {1'b0, 8'h10, 32'h0,         32'h1234_5678, 8'd6},   // R6 last entry high
    {1'b1, 8'h00, 32'h0000_003E, 32'h0, 8'd7},
    {1'b0, 8'h10, 32'h0,         32'h0001_0000, 8'd7},   // R7 last entry low kept
    {1'b1, 8'h00, 32'h0000_0040, 32'h0, 8'd8},
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 8'd8},
    {1'b0, 8'h10, 32'h0,         32'h0, 8'd8},           // R8 first index past end
    {1'b1, 8'h00, 32'h0000_00FF, 32'h0, 8'd8},
    {1'b0, 8'h10, 32'h0,         32'h0, 8'd8},           // R8 top selector
    {1'b1, 8'h04, 32'h0000_0055, 32'h0, 8'd2},
    {1'b0, 8'h04, 32'h0,         32'h0, 8'd2},           // R2 other offset zero
    {1'b0, 8'h00, 32'h0,         32'h0000_00FF, 8'd2},   // R2 selector untouched
    {1'b1, 8'h00, 32'h0000_0005, 32'h0, 8'd5},
    {1'b0, 8'h10, 32'h0,         32'h0, 8'd5},           // R5 reserved gap
    {1'b0, 8'h14, 32'h0,         32'h0, 8'd2}            // R2 near-window offset
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Writes and checks the strobe against the R9 rule
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    logic exp_svc;
    exp_svc = (a == 8'h10) && (sel_model >= 8'h10) && (sel_model < 8'h10 + 8'(2*N));
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    if (a == 8'h00) sel_model = d[7:0];
    chk("R9 strobe after write", {63'h0, svc_strobe}, {63'h0, exp_svc});
    @(negedge clk);
    chk("R9 strobe one cycle", {63'h0, svc_strobe}, 64'h0);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    v = rdata;
  endtask

  task automatic chk_all_reset(input string tag);
    for (int k = 0; k < N; k++)
      chk(tag, table_flat[64*k +: 64], 64'h0000_0000_0001_0000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 rdata", {32'h0, rdata}, 64'h0);
    chk("R10 strobe", {63'h0, svc_strobe}, 64'h0);
    chk_all_reset("R10 entry");

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        bus_write(VEC[i][79:72], VEC[i][71:40]);
      end else begin
        bus_read(VEC[i][79:72], rv);
        chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), {32'h0, rv}, {32'h0, VEC[i][39:8]});
      end
    end

    // R1 rdata holds until the next read
    repeat (3) @(negedge clk);
    chk("R1 rdata held", {32'h0, rdata}, 64'h0);
    bus_read(8'h00, rv);
    bus_write(8'h00, 32'h0000_0001);
    chk("R1 hold across write", {32'h0, rdata}, 64'h0000_0005);

    // R11 flat export
    chk("R11 entry 0", table_flat[63:0], 64'hDEAD_BEEF_A5A5_00C3);
    chk("R11 entry 23", table_flat[64*23 +: 64], 64'h1234_5678_0001_0000);
    chk("R11 entry 1 untouched", table_flat[64 +: 64], 64'h0000_0000_0001_0000);

    // R12 remote-IRR clear alone
    bus_write(8'h00, 32'h0000_001A);
    bus_write(8'h10, 32'h0000_4031);
    chk("R12 bit set", table_flat[64*5 +: 64], 64'h0000_0000_0000_4031);
    @(negedge clk);
    rirr_clr = '0; rirr_clr[5] = 1'b1;
    @(negedge clk);
    rirr_clr = '0;
    chk("R12 clear", table_flat[64*5 +: 64], 64'h0000_0000_0000_0031);
    chk("R12 neighbour", table_flat[64*4 +: 64], 64'h0000_0000_0001_0000);

    // R12 clear coinciding with a low-half write
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 8'h10; wdata = 32'h0000_4077;
    rirr_clr[5] = 1'b1;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; rirr_clr = '0;
    chk("R12 clear wins over write", table_flat[64*5 +: 64], 64'h0000_0000_0000_0077);
    chk("R9 strobe on coinciding write", {63'h0, svc_strobe}, 64'h1);

    // R3 ID survives other writes, then R10 mid-run reset
    bus_write(8'h00, 32'h0000_0000);
    bus_read(8'h10, rv);
    chk("R3 ID kept", {32'h0, rv}, 64'h0F00_0000);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    sel_model = 8'h00;
    @(negedge clk);
    chk_all_reset("R10 mid-run entry");
    bus_read(8'h00, rv);
    chk("R10 selector cleared", {32'h0, rv}, 64'h0);
    bus_read(8'h10, rv);
    chk("R10 ID cleared", {32'h0, rv}, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule